// File: doc/BRIEF.md
# Dual-Timing Read-Modify-Write Memory

This block is a single-port word memory with a small arithmetic/logic unit placed on its data path. Each request names an address, an operation and an operand. For an update operation the block fetches the stored word, combines it with the operand and writes the result back to the same address. The word that was stored before the update is returned on the read-data port.

A runtime timing select chooses between two schedules for an update. The low-power schedule completes the fetch, the combine and the write-back in a single clock cycle. The fast schedule splits the same update into a fetch phase and a combine-and-write phase, so the critical path is shorter and the clock can run faster. In both schedules the block asserts one activation strobe per request, so that row activations can be counted. Plain reads never write and take one cycle in either schedule.

A change of the timing select is taken up only while the block is idle. If the select changes during a split update, the change waits until that update has finished.

Top module: `dual_rmw_mem`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` and `row_act` are 0, `timing_now` is 0 (low-power schedule), and every memory word reads as zero.
- R2: In the low-power schedule (`timing_now`=0), an accepted update keeps `req_ready` high, so another request can be accepted on the very next edge. The pre-update word appears on `rsp_data` with `rsp_valid`=1 in the cycle after acceptance, and the new word is stored by that same edge.
- R3: Opcode encoding on `req_op`: 0 = read, 1 = add, 2 = bitwise AND, 3 = bitwise OR, 4 = pass (store the operand). Codes 5, 6 and 7 behave as read and leave memory unchanged.
- R4: In the fast schedule (`timing_now`=1), an accepted update drops `req_ready` for exactly one cycle. The pre-update word appears with `rsp_valid`=1 two cycles after acceptance, and the stored result is the same as in the low-power schedule.
- R5: `row_act` is high for exactly one cycle per accepted request, in the cycle that follows acceptance, in both schedules.
- R6: A read (or an unused opcode) completes in one cycle in both schedules. `req_ready` stays high and no word changes.
- R7: `timing_now` takes the value of `timing_sel` only on an edge where the block is idle and accepts no request. A change made while an update is in its second phase is deferred until that update has completed.
- R8: A request presented while `req_ready` is low is ignored: it produces no response and does not change memory.
- R9: Add wraps modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_arg | input | DATA_W | Operand |
| timing_sel | input | 1 | Requested schedule: 0 low-power, 1 fast |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | `rsp_data` holds a result |
| rsp_data | output | DATA_W | Word stored before the request |
| row_act | output | 1 | One-cycle row-activation strobe per request |
| timing_now | output | 1 | Schedule currently in force |

## Verification
The same mix of pass, add, AND, OR, reads and an unused opcode is run back-to-back under each schedule. Matching returned words and stored results show that the split path computes exactly what the single-cycle path computes, and the response-latency check shows which schedule was actually used. A pass of a high value followed by an add that overflows separates wrapping from saturating or widened arithmetic. A sequence that presents a second request and a schedule change while a split update is still busy shows whether the busy phase blocks requests and defers the schedule switch.

// File: rtl/dual_rmw_pkg.sv
package dual_rmw_pkg;

    typedef enum logic [2:0] {
        OP_READ = 3'd0,
        OP_ADD  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_PASS = 3'd4
    } rmw_fn_e;

    typedef enum logic {
        SCHED_LOWPWR = 1'b0,
        SCHED_FAST   = 1'b1
    } sched_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

    typedef struct packed {
        logic    writes;
        rmw_fn_e fn;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [2:0] code);
        op_dec_t d;
        case (code)
            3'd1:    begin d.writes = 1'b1; d.fn = OP_ADD;  end
            3'd2:    begin d.writes = 1'b1; d.fn = OP_AND;  end
            3'd3:    begin d.writes = 1'b1; d.fn = OP_OR;   end
            3'd4:    begin d.writes = 1'b1; d.fn = OP_PASS; end
            default: begin d.writes = 1'b0; d.fn = OP_READ; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import dual_rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rmw_fn_e             fn,
    input  logic [DATA_W-1:0]   stored,
    input  logic [DATA_W-1:0]   arg,
    output logic [DATA_W-1:0]   result
);
    always_comb begin
        case (fn)
            OP_ADD:  result = stored + arg;
            OP_AND:  result = stored & arg;
            OP_OR:   result = stored | arg;
            OP_PASS: result = arg;
            default: result = stored;
        endcase
    end
endmodule

// File: rtl/rmw_array.sv
module rmw_array #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows[g] <= '0;
            end else if (we && (addr == ADDR_W'(g))) begin
                rows[g] <= wdata;
            end
        end
    end

    assign rdata = rows[addr];
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import dual_rmw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  op_dec_t dec,
    input  logic    timing_sel,
    output logic    ready,
    output logic    accept,
    output logic    wr_now,
    output logic    split,
    output logic    wr_late,
    output logic    row_act,
    output logic    rsp_valid,
    output sched_e  sched
);
    phase_e phase_q;

    assign ready   = (phase_q == PH_IDLE);
    assign accept  = req_valid && ready;
    assign split   = accept && dec.writes && (sched == SCHED_FAST);
    assign wr_now  = accept && dec.writes && (sched == SCHED_LOWPWR);
    assign wr_late = (phase_q == PH_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            sched     <= SCHED_LOWPWR;
            row_act   <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            phase_q   <= split ? PH_WRITE : PH_IDLE;
            row_act   <= accept;
            rsp_valid <= (accept && !split) || wr_late;
            if (ready && !accept) begin
                sched <= sched_e'(timing_sel);
            end
        end
    end

    // R4
    ph2_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WRITE) |-> row_act);
    // R4
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WRITE) |=> (phase_q == PH_IDLE));
    // R7
    sched_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WRITE) |=> $stable(sched));
    // R2
    lowpwr_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && sched == SCHED_LOWPWR) |=> ready);
    // R5
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> row_act);
endmodule

// File: rtl/dual_rmw_mem.sv
module dual_rmw_mem
    import dual_rmw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_arg,
    input  logic                timing_sel,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                row_act,
    output logic                timing_now
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] arg;
        logic [DATA_W-1:0] fetched;
        rmw_fn_e           fn;
    } pend_t;

    op_dec_t           dec;
    logic              accept, wr_now, split, wr_late;
    sched_e            sched;
    pend_t             pend_q;
    logic [ADDR_W-1:0] arr_addr;
    logic              arr_we;
    logic [DATA_W-1:0] arr_rd, alu_a, alu_b, alu_y;
    rmw_fn_e           alu_fn;
    logic [DATA_W-1:0] rsp_q;

    assign dec = decode_op(req_op);

    rmw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .dec       (dec),
        .timing_sel(timing_sel),
        .ready     (req_ready),
        .accept    (accept),
        .wr_now    (wr_now),
        .split     (split),
        .wr_late   (wr_late),
        .row_act   (row_act),
        .rsp_valid (rsp_valid),
        .sched     (sched)
    );

    assign arr_addr = wr_late ? pend_q.addr : req_addr;
    assign arr_we   = wr_now || wr_late;
    assign alu_a    = wr_late ? pend_q.fetched : arr_rd;
    assign alu_b    = wr_late ? pend_q.arg : req_arg;
    assign alu_fn   = wr_late ? pend_q.fn : dec.fn;

    rmw_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk  (clk),
        .rst  (rst),
        .addr (arr_addr),
        .we   (arr_we),
        .wdata(alu_y),
        .rdata(arr_rd)
    );

    rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .fn    (alu_fn),
        .stored(alu_a),
        .arg   (alu_b),
        .result(alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            rsp_q  <= '0;
        end else begin
            if (split) begin
                pend_q.addr    <= req_addr;
                pend_q.arg     <= req_arg;
                pend_q.fetched <= arr_rd;
                pend_q.fn      <= dec.fn;
            end
            if (accept && !split) begin
                rsp_q <= arr_rd;
            end else if (wr_late) begin
                rsp_q <= pend_q.fetched;
            end
        end
    end

    assign rsp_data   = rsp_q;
    assign timing_now = sched;

    // R6
    read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec.writes) |-> !arr_we);
    // R4
    late_resp_chk: assert property (@(posedge clk) disable iff (rst)
        wr_late |=> rsp_valid);
endmodule

// File: tb/dual_rmw_mem_tb.sv
module dual_rmw_mem_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DEP = 16;
    localparam int AW = $clog2(DEP);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_arg = '0;
    logic          timing_sel = 1'b0;
    logic          req_ready, rsp_valid, row_act, timing_now;
    logic [DW-1:0] rsp_data;

    dual_rmw_mem #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_arg(req_arg), .timing_sel(timing_sel),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .row_act(row_act), .timing_now(timing_now)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int accepts = 0;
    int strobes = 0;
    bit finished = 0;
    bit bench_fast = 0;
    logic [DW-1:0] model [DEP];
    logic [DW-1:0] exp_data [$];
    int            exp_cyc [$];
    string         exp_tag [$];

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] apply(input logic [2:0] op, input logic [DW-1:0] s,
                                            input logic [DW-1:0] a);
        case (op)
            3'd1: return s + a;
            3'd2: return s & a;
            3'd3: return s | a;
            3'd4: return a;
            default: return s;
        endcase
    endfunction

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (!rst) begin
            if (row_act) strobes++;
            if (rsp_valid) begin
                if (exp_data.size() == 0) begin
                    check(0, "R8 unexpected response", rsp_data, 0);
                end else begin
                    automatic logic [DW-1:0] d = exp_data.pop_front();
                    automatic int c = exp_cyc.pop_front();
                    automatic string t = exp_tag.pop_front();
                    check(rsp_data == d, {t, " data"}, rsp_data, d);
                    check(cyc == c, {t, " latency"}, cyc, c);
                end
            end
        end
    end

    // driver: waits for ready, drives one request, predicts the response
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] arg, input string tag);
        automatic bit wr = (op >= 3'd1 && op <= 3'd4);
        automatic bit two = wr && bench_fast;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_arg = arg;
        exp_data.push_back(model[a]);
        exp_cyc.push_back(cyc + (two ? 2 : 1));
        exp_tag.push_back(tag);
        model[a] = apply(op, model[a], arg);
        accepts++;
        @(negedge clk);
        req_valid = 1'b0;
        // R2 stays ready in low-power, R4 busy one cycle in fast, R6 reads never busy
        check(req_ready == !two, two ? "R4 busy" : "R2/R6 ready", req_ready, !two);
    endtask

    task automatic set_sched(input bit m);
        @(negedge clk);
        timing_sel = m;
        @(negedge clk);
        @(negedge clk);
        check(timing_now == m, "R7 schedule switch", timing_now, m);
        bench_fast = m;
    endtask

    task automatic op_mix(input string sfx);
        issue(3'd4, 4'd2, 8'hA5, {"R3 pass ", sfx});
        issue(3'd1, 4'd2, 8'h10, {"R3 add ", sfx});
        issue(3'd2, 4'd2, 8'h0F, {"R3 and ", sfx});
        issue(3'd3, 4'd2, 8'h30, {"R3 or ", sfx});
        issue(3'd0, 4'd2, 8'h00, {"R6 read ", sfx});
        issue(3'd4, 4'd5, 8'hF0, {"R9 pass ", sfx});
        issue(3'd1, 4'd5, 8'h25, {"R9 add wrap ", sfx});
        issue(3'd6, 4'd5, 8'hFF, {"R3 unused code ", sfx});
        issue(3'd0, 4'd5, 8'h00, {"R9 read back ", sfx});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEP; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(row_act == 1'b0, "R1 row_act", row_act, 0);
        check(timing_now == 1'b0, "R1 timing_now", timing_now, 0);
        issue(3'd0, 4'd3, 8'h00, "R1 zero word");

        op_mix("lowpwr R2");
        set_sched(1'b1);
        op_mix("fast R4");

        // R8 and R7: request and schedule change while second phase is busy
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4; req_addr = 4'd7; req_arg = 8'h11;
        exp_data.push_back(model[7]); exp_cyc.push_back(cyc + 2);
        exp_tag.push_back("R4 busy pass");
        model[7] = 8'h11;
        accepts++;
        @(negedge clk);
        check(req_ready == 1'b0, "R4 busy", req_ready, 0);
        req_op = 3'd4; req_addr = 4'd8; req_arg = 8'h77;
        timing_sel = 1'b0;
        check(timing_now == 1'b1, "R7 held during busy", timing_now, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(timing_now == 1'b1, "R7 deferred", timing_now, 1);
        @(negedge clk);
        check(timing_now == 1'b0, "R7 applied when idle", timing_now, 0);
        bench_fast = 0;
        issue(3'd0, 4'd8, 8'h00, "R8 ignored write");
        issue(3'd0, 4'd7, 8'h00, "R4 fast result");

        repeat (4) @(negedge clk);
        check(exp_data.size() == 0, "R2 all responses seen", exp_data.size(), 0);
        check(strobes == accepts, "R5 one strobe per request", strobes, accepts);
        finish_run();
    end
endmodule